// File: doc/BRIEF.md
# Base and Bound Address Relocation Unit

This unit sits on the path from a processor to its memory bus. It turns every virtual load or store address into a physical address by adding a base register. It then admits the access only if the physical address is below an absolute upper-bound register. The comparison is made after the addition, so the bound is a physical address and not a segment length.

Privileged software loads the two registers through a small configuration port, typically when it switches from one process to another. Request traffic cannot touch them.

Each request carries a valid strobe and a virtual address. One clock later the unit reports one of two results. Either the access passes, with its physical address, or it is refused with an access fault that the processor turns into an exception.

Top module: `reloc_unit`

## Requirements
- R1: For a passing access, the physical address equals base plus the zero-extended virtual address, for example base 0x1400 with virtual 0x352 gives 0x1752.
- R2: An access passes only if its physical address is strictly below the bound register. A physical address equal to or above the bound faults, for example 0x2222 against bound 0x2000.
- R3: If the addition carries out of the physical address width, the access faults whatever the bound.
- R4: A request with the valid strobe high in one cycle produces exactly one result in the next cycle. A cycle without a request produces no result.
- R5: The pass and fault outputs are never high together. The physical address output reads zero whenever pass is low.
- R6: Base and bound change only on a configuration write. Select value 0 writes base and select value 1 writes bound. With the write enable low, the select and data inputs and all access traffic have no effect on the registers.
- R7: A configuration write in the same cycle as an access leaves that access on the old register values. It takes effect from the following access onward.
- R8: Synchronous active-high reset clears base and bound to zero and drives all result outputs low. Every access then faults until software configures the unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable (privileged) |
| cfg_sel | input | 1 | Register select: 0 base, 1 bound |
| cfg_wdata | input | PA_W | Value written to the selected register |
| req_valid | input | 1 | Access request strobe |
| req_vaddr | input | VA_W | Virtual address of the access |
| rsp_ok | output | 1 | Access passed, physical address valid |
| rsp_fault | output | 1 | Access refused, raise exception |
| rsp_paddr | output | PA_W | Translated physical address (zero unless rsp_ok) |

## Verification
Translation is tried with addresses well inside the window, addresses exactly one below and exactly at the bound, and addresses far beyond it. These separate an inclusive bound from an exclusive one, and a correct compare from a pre-add length check. A base near the top of the address space, paired with a maximal bound, shows whether an adder carry wraps silently into a small passing address. Configuration writes issued in the same cycle as an access, and writes with the enable low, tell whether requests see the old register values, and whether a stray select or data value leaks into a register. Idle gaps and back-to-back requests confirm a fixed one-cycle latency with no phantom results.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

    localparam int unsigned DEF_VA_W = 16;
    localparam int unsigned DEF_PA_W = 16;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_BOUND = 1'b1
    } cfg_sel_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'b00,
        RES_PASS  = 2'b01,
        RES_FAULT = 2'b10
    } result_e;

    function automatic result_e classify(input logic valid, input logic fault);
        if (!valid)
            return RES_NONE;
        else if (fault)
            return RES_FAULT;
        else
            return RES_PASS;
    endfunction

endpackage

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs
    import reloc_pkg::*;
#(
    parameter int unsigned PA_W = DEF_PA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  cfg_sel_e        sel,
    input  logic [PA_W-1:0] wdata,
    output logic [PA_W-1:0] base_q,
    output logic [PA_W-1:0] bound_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            bound_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_BASE:  base_q  <= wdata;
                SEL_BOUND: bound_q <= wdata;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
    import reloc_pkg::*;
#(
    parameter int unsigned VA_W = DEF_VA_W,
    parameter int unsigned PA_W = DEF_PA_W
) (
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] bound,
    input  logic [VA_W-1:0] vaddr,
    output logic [PA_W-1:0] paddr,
    output logic            fault
);

    localparam int unsigned SUM_W = PA_W + 1;
    localparam int unsigned EXT_W = SUM_W - VA_W;

    logic [SUM_W-1:0] va_ext;
    logic [SUM_W-1:0] sum;
    logic             carry;
    logic             over;

    generate
        if (EXT_W > 0) begin : g_ext
            assign va_ext = {{EXT_W{1'b0}}, vaddr};
        end else begin : g_trunc
            assign va_ext = vaddr[SUM_W-1:0];
        end
    endgenerate

    always_comb begin
        sum   = {1'b0, base} + va_ext;
        carry = sum[PA_W];
        paddr = sum[PA_W-1:0];
        over  = (paddr >= bound);
        fault = carry | over;
    end

endmodule

// File: rtl/reloc_out_stage.sv
module reloc_out_stage
    import reloc_pkg::*;
#(
    parameter int unsigned PA_W = DEF_PA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic            fault,
    input  logic [PA_W-1:0] paddr,
    output logic            ok_q,
    output logic            fault_q,
    output logic [PA_W-1:0] paddr_q
);

    typedef struct packed {
        logic            ok;
        logic            flt;
        logic [PA_W-1:0] pa;
    } resp_t;

    resp_t   nxt;
    resp_t   cur;
    result_e res;

    always_comb begin
        res     = classify(valid, fault);
        nxt.ok  = (res == RES_PASS);
        nxt.flt = (res == RES_FAULT);
        nxt.pa  = (res == RES_PASS) ? paddr : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end

    assign ok_q    = cur.ok;
    assign fault_q = cur.flt;
    assign paddr_q = cur.pa;

endmodule

// File: rtl/reloc_unit.sv
module reloc_unit
    import reloc_pkg::*;
#(
    parameter int unsigned VA_W = DEF_VA_W,
    parameter int unsigned PA_W = DEF_PA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            rsp_ok,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_paddr
);

    logic [PA_W-1:0] base_q;
    logic [PA_W-1:0] bound_q;
    logic [PA_W-1:0] xl_paddr;
    logic            xl_fault;
    cfg_sel_e        sel_e;

    assign sel_e = cfg_sel_e'(cfg_sel);

    reloc_cfg_regs #(.PA_W(PA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (sel_e),
        .wdata  (cfg_wdata),
        .base_q (base_q),
        .bound_q(bound_q)
    );

    reloc_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
        .base (base_q),
        .bound(bound_q),
        .vaddr(req_vaddr),
        .paddr(xl_paddr),
        .fault(xl_fault)
    );

    reloc_out_stage #(.PA_W(PA_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .valid  (req_valid),
        .fault  (xl_fault),
        .paddr  (xl_paddr),
        .ok_q   (rsp_ok),
        .fault_q(rsp_fault),
        .paddr_q(rsp_paddr)
    );

endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
    parameter int unsigned VA_W = 16,
    parameter int unsigned PA_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_we,
    input logic [PA_W-1:0] base_q,
    input logic [PA_W-1:0] bound_q,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_ok,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr
);

    AST_OK_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_ok && rsp_fault)); // R5

    AST_PADDR_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rsp_ok |-> (rsp_paddr == '0)); // R5

    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_ok || rsp_fault)); // R4

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_ok || rsp_fault)); // R4

    AST_PASS_SUM: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_ok -> (rsp_paddr == PA_W'($past(base_q) + $past(req_vaddr))))); // R1

    AST_PASS_BELOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_ok -> (rsp_paddr < $past(bound_q)))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_ok -> (rsp_paddr >= $past(base_q)))); // R3

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(base_q) && $stable(bound_q))); // R6

endmodule

bind reloc_unit reloc_unit_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .base_q   (base_q),
    .bound_q  (bound_q),
    .req_valid(req_valid),
    .req_vaddr(req_vaddr),
    .rsp_ok   (rsp_ok),
    .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
);

// File: tb/reloc_unit_bench.sv
`timescale 1ns/1ps
module reloc_unit_bench;

    localparam int unsigned VA_W = 16;
    localparam int unsigned PA_W = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic            cfg_sel = 1'b0;
    logic [PA_W-1:0] cfg_wdata = '0;
    logic            req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            rsp_ok;
    logic            rsp_fault;
    logic [PA_W-1:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic            ok;
        logic            flt;
        logic [PA_W-1:0] pa;
        string           tag;
    } exp_t;

    exp_t exp_q[$];

    logic [PA_W-1:0] m_base  = '0;
    logic [PA_W-1:0] m_bound = '0;

    always #2 clk = ~clk;

    reloc_unit #(.VA_W(VA_W), .PA_W(PA_W)) u_reloc_unit (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .req_valid(req_valid),
        .req_vaddr(req_vaddr),
        .rsp_ok   (rsp_ok),
        .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string tag, input logic [PA_W+1:0] got, input logic [PA_W+1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got ok/flt/pa=%h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // One clock of stimulus: optional config write and optional access.
    task automatic cyc(input bit we, input bit sel, input logic [PA_W-1:0] wd,
                       input bit v, input logic [VA_W-1:0] va, input string tag);
        logic [PA_W:0] s;
        exp_t e;
        @(negedge clk);
        cfg_we    = we;
        cfg_sel   = sel;
        cfg_wdata = wd;
        req_valid = v;
        req_vaddr = va;
        if (v) begin
            s     = {1'b0, m_base} + {{(PA_W+1-VA_W){1'b0}}, va};
            e.ok  = !s[PA_W] && (s[PA_W-1:0] < m_bound);
            e.flt = !e.ok;
            e.pa  = e.ok ? s[PA_W-1:0] : '0;
            e.tag = tag;
            exp_q.push_back(e);
        end
        if (we) begin
            if (sel) m_bound = wd;
            else     m_base  = wd;
        end
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, '0, 1'b0, '0, "idle");
    endtask

    // Monitor: results appear exactly one edge after the request.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (!rst) begin
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    check(e.tag, {rsp_ok, rsp_fault, rsp_paddr}, {e.ok, e.flt, e.pa});
                end else begin
                    check("R4 no result without request", {rsp_ok, rsp_fault, rsp_paddr}, '0);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 outputs low in reset", {rsp_ok, rsp_fault, rsp_paddr}, '0);
        rst = 1'b0;

        // R8: unconfigured unit faults every access
        cyc(0, 0, '0, 1, 16'h0000, "R8 fault after reset va 0");
        cyc(0, 0, '0, 1, 16'h0352, "R8 fault after reset va 352");

        // R6: sel 0 = base, sel 1 = bound
        cyc(1, 0, 16'h1400, 0, '0, "cfg");
        cyc(1, 1, 16'h2000, 0, '0, "cfg");

        cyc(0, 0, '0, 1, 16'h0352, "R1 0x352 -> 0x1752");
        cyc(0, 0, '0, 1, 16'h0000, "R1 0x0 -> 0x1400");
        idle();
        cyc(0, 0, '0, 1, 16'h0E22, "R2 phys 0x2222 faults");
        cyc(0, 0, '0, 1, 16'h0BFF, "R2 bound-1 passes");
        cyc(0, 0, '0, 1, 16'h0C00, "R2 equal to bound faults");
        idle();
        idle();

        // R7: same-cycle write uses old values
        cyc(1, 1, 16'h4000, 1, 16'h2000, "R7 old bound in write cycle");
        cyc(0, 0, '0, 1, 16'h2000, "R7 new bound next access");
        cyc(1, 0, 16'h3000, 1, 16'h0010, "R7 old base in write cycle");
        cyc(0, 0, '0, 1, 16'h0010, "R7 new base next access");

        // R3: carry out faults
        cyc(1, 0, 16'hF000, 0, '0, "cfg");
        cyc(1, 1, 16'hFFFF, 0, '0, "cfg");
        cyc(0, 0, '0, 1, 16'h1000, "R3 carry faults");
        cyc(0, 0, '0, 1, 16'hFFFF, "R3 large carry faults");
        cyc(0, 0, '0, 1, 16'h0FFE, "R3 top passes without carry");

        // R6: disabled writes change nothing
        cyc(0, 0, 16'h0000, 1, 16'h0010, "R6 base held with we low");
        cyc(0, 1, 16'h0000, 1, 16'h0020, "R6 bound held with we low");
        cyc(0, 0, '0, 1, 16'h0030, "R6 regs unchanged after traffic");

        // R8: reset mid-run clears registers
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
        rst       = 1'b1;
        exp_q.delete();
        @(negedge clk);
        check("R8 outputs low after mid-run reset", {rsp_ok, rsp_fault, rsp_paddr}, '0);
        rst     = 1'b0;
        m_base  = '0;
        m_bound = '0;
        cyc(0, 0, '0, 1, 16'h0010, "R8 fault after mid-run reset");
        idle();
        idle();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule